// File: doc/BRIEF.md
# Configurable-Width Serial Sample Serializer

This block turns parallel 12-bit converter samples into one double-data-rate serial lane. The design runs on a clock whose period is one bit slot. Each slot carries one data bit. A bit-clock output changes level every slot, so that the receiver can capture data on both of its edges. One sample is accepted per word time over a valid/ready handshake. The word is then shifted out over 8, 10, 12 or 14 slots. A frame marker is high for the first half of every word. A phase code for an external delay element sets where the bit clock lands relative to the data edges, in 60 degree steps.

Three controls select the word format. The word length either keeps only the most significant bits of the sample or adds two zero bits after them. The bit order is most-significant-first or least-significant-first. The invert control complements every bit on the line. Bit order and inversion are independent of each other. All controls, including the phase select, are sampled only when a sample is accepted. A word that is already in flight keeps its own settings.

The controller has two states. In `ST_IDLE` the lane is quiet and the block waits for a sample. In `ST_SEND` a word is on the line. The transition LOAD goes from `ST_IDLE` to `ST_SEND` when a sample is accepted. CHAIN stays in `ST_SEND` when a new sample is accepted in the last slot of a word. DRAIN goes from `ST_SEND` back to `ST_IDLE` when the last slot ends with no new sample.

Top module: `lane_serializer`

## Requirements
- R1: While reset is held and right after it, `ser_bit`, `frame_mark` and `bit_clk` are 0, `phase_code` is 3, and `smp_ready` is 1.
- R2: `smp_ready` is 1 while idle and during the last slot of a word, and 0 in every other slot. A sample is taken at a clock edge where `smp_valid` and `smp_ready` are both 1, and its first bit appears in the slot that follows that edge.
- R3: The word-length select sets the number of slots per word: 2'b00 gives 12, 2'b01 gives 8, 2'b10 gives 10 and 2'b11 gives 14. Words accepted back to back follow each other with no gap.
- R4: With `lsb_first`=0, the line carries `smp_data[11]` first and continues downward. The 8- and 10-slot lengths send only the upper 8 or 10 sample bits.
- R5: In the 14-slot length, the 12 sample bits are followed by two zero bits (before any inversion), in either bit order.
- R6: With `lsb_first`=1, the data bits go out in ascending order, starting at `smp_data[12-N]` when N is 8 or 10, and at `smp_data[0]` when N is 12 or 14. Any padding still comes last.
- R7: With `invert`=1, every slot of the word, padding included, is complemented. Inversion does not change the bit order.
- R8: `frame_mark` is 1 for the first N/2 slots of an N-slot word and 0 for the remaining slots.
- R9: Changes to the length, order, invert or phase controls while a word is in flight have no effect on that word.
- R10: When no word is in flight, `ser_bit` and `frame_mark` are 0.
- R11: After reset, `bit_clk` changes level on every clock cycle.
- R12: `phase_code` counts in 30 degree units. When a sample is accepted with `phase_sel` between 0 and 5, it becomes 2*`phase_sel` (0 to 300 degrees). A `phase_sel` of 6 or 7 leaves it unchanged. It changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | 12 | Parallel sample |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample can be taken at this edge |
| len_sel | input | 2 | Word length select (R3 encoding) |
| lsb_first | input | 1 | 1 selects least-significant-first order |
| invert | input | 1 | 1 complements every line bit |
| phase_sel | input | 3 | Bit-clock phase request in 60 degree steps |
| ser_bit | output | 1 | Serial data, one bit per slot |
| frame_mark | output | 1 | High for the first half of each word |
| bit_clk | output | 1 | Bit clock, changes level every slot |
| phase_code | output | 4 | Bit-clock delay in 30 degree units, for the delay element |

## Verification
Some properties are checked on every cycle. These are: the bit clock toggles every cycle; a quiet lane outside `ST_SEND`; the slot counter staying inside the latched word length; the frame marker opening every accepted word; ready being low while the marker is high; and a phase code that only takes legal values and moves only on an accepted sample. The actual bit values on the line can only be shown by the bench's scenarios, which compare the line against a slot-by-slot model. These include the truncated and padded lengths in both orders, inversion combined with either order, chained words, and controls changed in the middle of a word.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [1:0] {
        WL_NORMAL  = 2'b00,
        WL_SHORT_A = 2'b01,
        WL_SHORT_B = 2'b10,
        WL_PADDED  = 2'b11
    } wlen_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ser_state_e;

    // Slots per word for a length select, given sample width and pad step.
    function automatic int unsigned slots_for(wlen_e m, int unsigned base, int unsigned pad);
        int unsigned r;
        unique case (m)
            WL_NORMAL:  r = base;
            WL_SHORT_A: r = base - 2 * pad;
            WL_SHORT_B: r = base - pad;
            WL_PADDED:  r = base + pad;
            default:    r = base;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsr_word_fsm.sv
module lsr_word_fsm
    import lsr_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned PAD_W    = 2,
    parameter int unsigned CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  wlen_e            len_sel,
    output logic             in_ready,
    output logic             load,
    output logic             sending,
    output logic             frame,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] slots
);

    ser_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] slots_q, slots_d;
    logic             last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            slots_q <= CNT_W'(SAMPLE_W);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            slots_q <= slots_d;
        end
    end

    // outputs
    always_comb begin
        last     = (state_q == ST_SEND) && (cnt_q == slots_q - CNT_W'(1));
        in_ready = (state_q == ST_IDLE) || last;
        load     = in_ready && in_valid;
        sending  = (state_q == ST_SEND);
        frame    = sending && (cnt_q < (slots_q >> 1));
        cnt      = cnt_q;
        slots    = slots_q;
    end

    // next state: LOAD, CHAIN, DRAIN
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        slots_d = slots_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (last && !load) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (load) begin
            cnt_d   = '0;
            slots_d = CNT_W'(slots_for(len_sel, SAMPLE_W, PAD_W));
        end else if (state_q == ST_SEND) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lsr_shifter.sv
module lsr_shifter
    import lsr_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned PAD_W    = 2,
    parameter int unsigned CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                sending,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  wlen_e               len_sel,
    input  logic                lsb_first,
    input  logic                invert,
    output logic                ser_bit
);

    localparam int unsigned MAX_W = SAMPLE_W + PAD_W;

    logic [CNT_W-1:0]    slots_w;
    logic [CNT_W-1:0]    ndata_w;
    logic [SAMPLE_W-1:0] dsh;
    logic [MAX_W-1:0]    word_pos;   // index = transmit position
    logic [MAX_W-1:0]    loaded;     // index MAX_W-1 goes first
    logic [MAX_W-1:0]    sreg_q;
    logic                inv_q;

    assign slots_w = CNT_W'(slots_for(len_sel, SAMPLE_W, PAD_W));
    assign ndata_w = (slots_w > CNT_W'(SAMPLE_W)) ? CNT_W'(SAMPLE_W) : slots_w;
    assign dsh     = smp_data >> (CNT_W'(SAMPLE_W) - ndata_w);

    for (genvar i = 0; i < MAX_W; i++) begin : g_pos
        if (i < SAMPLE_W) begin : g_data
            assign word_pos[i] = (ndata_w > CNT_W'(i)) &&
                                 (lsb_first ? dsh[i] : smp_data[SAMPLE_W-1-i]);
        end else begin : g_pad
            assign word_pos[i] = 1'b0;
        end
        assign loaded[MAX_W-1-i] = word_pos[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            inv_q  <= 1'b0;
        end else if (load) begin
            sreg_q <= loaded;
            inv_q  <= invert;
        end else if (sending) begin
            sreg_q <= {sreg_q[MAX_W-2:0], 1'b0};
        end
    end

    always_comb begin
        ser_bit = sending && (sreg_q[MAX_W-1] ^ inv_q);
    end

endmodule

// File: rtl/lsr_clk_phase.sv
module lsr_clk_phase #(
    parameter int unsigned PH_W       = 3,
    parameter int unsigned PH_STEPS   = 6,
    parameter int unsigned RESET_CODE = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PH_W-1:0] phase_sel,
    output logic            bit_clk,
    output logic [PH_W:0]   phase_code
);

    logic          bclk_q;
    logic [PH_W:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            code_q <= (PH_W+1)'(RESET_CODE);
        end else begin
            bclk_q <= ~bclk_q;
            if (load && (phase_sel < PH_W'(PH_STEPS))) begin
                code_q <= {phase_sel, 1'b0};
            end
        end
    end

    assign bit_clk    = bclk_q;
    assign phase_code = code_q;

endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
    import lsr_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = 12,
    parameter int unsigned PAD_W     = 2,
    parameter int unsigned PH_W      = 3,
    parameter int unsigned PH_STEPS  = 6,
    parameter int unsigned PH_RESET  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [1:0]          len_sel,
    input  logic                lsb_first,
    input  logic                invert,
    input  logic [PH_W-1:0]     phase_sel,
    output logic                ser_bit,
    output logic                frame_mark,
    output logic                bit_clk,
    output logic [PH_W:0]       phase_code
);

    localparam int unsigned MAX_W  = SAMPLE_W + PAD_W;
    localparam int unsigned CNT_W  = $clog2(MAX_W + 1);
    localparam int unsigned CODE_W = PH_W + 1;

    wlen_e            len_e;
    logic             word_load;
    logic             sending;
    logic [CNT_W-1:0] fsm_cnt;
    logic [CNT_W-1:0] fsm_slots;

    assign len_e = wlen_e'(len_sel);

    lsr_word_fsm #(
        .SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .len_sel(len_e),
        .in_ready(smp_ready), .load(word_load), .sending(sending),
        .frame(frame_mark), .cnt(fsm_cnt), .slots(fsm_slots)
    );

    lsr_shifter #(
        .SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W), .CNT_W(CNT_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .load(word_load), .sending(sending),
        .smp_data(smp_data), .len_sel(len_e), .lsb_first(lsb_first),
        .invert(invert), .ser_bit(ser_bit)
    );

    lsr_clk_phase #(
        .PH_W(PH_W), .PH_STEPS(PH_STEPS), .RESET_CODE(PH_RESET)
    ) u_clk (
        .clk(clk), .rst_n(rst_n), .load(word_load), .phase_sel(phase_sel),
        .bit_clk(bit_clk), .phase_code(phase_code)
    );

endmodule

// File: rtl/lsr_checks.sv
module lsr_checks #(
    parameter int unsigned CNT_W      = 4,
    parameter int unsigned CODE_W     = 4,
    parameter int unsigned RESET_CODE = 3,
    parameter int unsigned MAX_CODE   = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_ready,
    input logic              word_load,
    input logic              sending,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  slots,
    input logic              ser_bit,
    input logic              frame_mark,
    input logic              bit_clk,
    input logic [CODE_W-1:0] phase_code
);

    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_bclk_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        bit_clk != $past(bit_clk));

    p_ready_low_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |-> !smp_ready);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sending |-> (!ser_bit && !frame_mark));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sending |-> (cnt < slots));

    p_word_opens_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(word_load) |-> (sending && frame_mark && cnt == '0));

    p_phase_hold_r12: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !$past(word_load) |-> $stable(phase_code));

    p_phase_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == CODE_W'(RESET_CODE)) ||
        (!phase_code[0] && phase_code <= CODE_W'(MAX_CODE)));

endmodule

bind lane_serializer lsr_checks #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .RESET_CODE(PH_RESET),
    .MAX_CODE(2 * (PH_STEPS - 1))
) chk_i (
    .clk(clk), .rst_n(rst_n), .smp_ready(smp_ready), .word_load(word_load),
    .sending(sending), .cnt(fsm_cnt), .slots(fsm_slots), .ser_bit(ser_bit),
    .frame_mark(frame_mark), .bit_clk(bit_clk), .phase_code(phase_code)
);

// File: tb/lane_serializer_tb_top.sv
`timescale 1ns/1ps
module lane_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [1:0]  len_sel = 2'b00;
    logic        lsb_first = 1'b0;
    logic        invert = 1'b0;
    logic [2:0]  phase_sel = 3'd0;
    logic        ser_bit, frame_mark, bit_clk;
    logic [3:0]  phase_code;

    int errors = 0;
    int checks = 0;
    bit running = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    lane_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .len_sel(len_sel), .lsb_first(lsb_first),
        .invert(invert), .phase_sel(phase_sel), .ser_bit(ser_bit),
        .frame_mark(frame_mark), .bit_clk(bit_clk), .phase_code(phase_code)
    );

    // ---------------- behavioural slot model ----------------
    bit    q_bit[$];
    bit    q_frm[$];
    string q_tag[$];
    bit    m_bclk = 0;
    int    m_phase = 3;
    bit    m_acc = 0;
    string cur_tag = "R10";

    function automatic int len_of(logic [1:0] s);
        case (s)
            2'b01:   return 8;
            2'b10:   return 10;
            2'b11:   return 14;
            default: return 12;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q_bit.delete(); q_frm.delete(); q_tag.delete();
            m_bclk = 0; m_phase = 3; m_acc = 0;
        end else begin
            int  n, nd;
            bit  b;
            m_acc = smp_valid && (q_bit.size() <= 1);
            m_bclk = ~m_bclk;
            if (q_bit.size() > 0) begin
                void'(q_bit.pop_front()); void'(q_frm.pop_front()); void'(q_tag.pop_front());
            end
            if (m_acc) begin
                n  = len_of(len_sel);
                nd = (n < 12) ? n : 12;
                for (int i = 0; i < n; i++) begin
                    if (i < nd) b = lsb_first ? smp_data[12 - nd + i] : smp_data[11 - i];
                    else        b = 1'b0;
                    q_bit.push_back(b ^ invert);
                    q_frm.push_back(i < n / 2);
                    q_tag.push_back(cur_tag);
                end
                if (phase_sel <= 3'd5) m_phase = 2 * phase_sel;
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            bit eb, ef;
            string t;
            eb = (q_bit.size() > 0) ? q_bit[0] : 1'b0;
            ef = (q_frm.size() > 0) ? q_frm[0] : 1'b0;
            t  = (q_tag.size() > 0) ? q_tag[0] : "R10";
            chk(ser_bit == eb, t, "ser_bit", ser_bit, eb);
            chk(frame_mark == ef, "R8", "frame_mark", frame_mark, ef);
            chk(smp_ready == (q_bit.size() <= 1), "R2", "smp_ready", smp_ready, q_bit.size() <= 1);
            chk(bit_clk == m_bclk, "R11", "bit_clk", bit_clk, m_bclk);
            chk(int'(phase_code) == m_phase, "R12", "phase_code", phase_code, m_phase);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(logic [11:0] d, logic [1:0] wl, bit lsb, bit inv, logic [2:0] ph, string tag);
        smp_data = d; len_sel = wl; lsb_first = lsb; invert = inv; phase_sel = ph;
        cur_tag = tag; smp_valid = 1'b1;
        forever begin
            @(posedge clk);
            @(negedge clk);
            if (m_acc) break;
        end
        smp_valid = 1'b0;
    endtask

    task automatic idle(int n);
        smp_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ser_bit == 0, "R1", "ser_bit", ser_bit, 0);
        chk(frame_mark == 0, "R1", "frame_mark", frame_mark, 0);
        chk(bit_clk == 0, "R1", "bit_clk", bit_clk, 0);
        chk(phase_code == 4'd3, "R1", "phase_code", phase_code, 3);
        chk(smp_ready == 1, "R1", "smp_ready", smp_ready, 1);
        rst_n = 1'b1;
        running = 1;
        idle(4);                                                   // R10 idle lane
        send(12'hA5C, 2'b00, 0, 0, 3'd7, "R4");                   // default format
        send(12'h3F1, 2'b00, 0, 0, 3'd7, "R3");                   // chained word
        send(12'hB6D, 2'b01, 0, 0, 3'd7, "R3");                   // 8 slots
        send(12'h2C7, 2'b10, 0, 0, 3'd7, "R4");                   // 10 slots
        idle(3);
        send(12'hFFF, 2'b11, 0, 0, 3'd7, "R5");                   // padding msb-first
        send(12'h801, 2'b11, 1, 0, 3'd7, "R5");                   // padding lsb-first
        send(12'h1E3, 2'b00, 1, 0, 3'd7, "R6");
        send(12'hC35, 2'b01, 1, 0, 3'd7, "R6");
        send(12'h6A9, 2'b10, 1, 0, 3'd7, "R6");
        send(12'h0F0, 2'b00, 0, 1, 3'd7, "R7");
        send(12'h0F0, 2'b11, 1, 1, 3'd7, "R7");                   // padding inverted
        send(12'h123, 2'b01, 0, 1, 3'd7, "R7");
        idle(2);
        for (int p = 0; p < 8; p++) begin
            send(12'(p * 331), 2'(p % 4), 1'(p % 2), 1'(p / 4), 3'(p), "R12");
        end
        // R9: controls move mid-word, word must keep its own settings
        send(12'h9C4, 2'b00, 0, 0, 3'd1, "R9");
        idle(2);
        len_sel = 2'b01; lsb_first = 1; invert = 1; phase_sel = 3'd4;
        idle(3);
        len_sel = 2'b11; invert = 0;
        idle(10);
        // R2: late valid, word after idle gap
        idle(5);
        send(12'h5A5, 2'b10, 0, 1, 3'd2, "R2");
        idle(20);
        summary();
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        summary();
    end

endmodule